// File: doc/BRIEF.md
# Configurable Two-Input Logic Element Array

This block is a small programmable logic fabric. It has sixteen identical logic elements in two groups of eight: group 0 holds elements 0 to 7 and group 1 holds elements 8 to 15. Each element takes two input bits, A and B, and applies one of the sixteen possible two-input Boolean functions to them. The element then presents the result either directly or through its own flip-flop. Input A is either a bit from a software-written data word or the output of an even-numbered element in the same group. Input B is either the element's external pin or the output of an odd-numbered element in the same group. This routing lets small state machines and glue logic be built without changing the RTL.

All state lives on one system clock. Each group's flip-flops advance only when that group's selected clock source produces an enable strobe. Five of the sources arrive as external strobe inputs. The system-clock source fires on every cycle. Software programs the fabric through a simple write port and reads it back through an address-selected read port.

Top module: `lcf_fabric`

## Requirements
- R1: After reset, every control word, the clock-select register and the software data word read as zero, and every element output is 0.
- R2: Control bits 4:1 form a truth table indexed by {A,B}, where A has weight 2 and B has weight 1. The function codes are: 0 = 0, 1 = NOR, 2 = B&~A, 3 = ~A, 4 = A&~B, 5 = ~B, 6 = XOR, 7 = NAND, 8 = AND, 9 = XNOR, 10 = B, 11 = ~A|B, 12 = A, 13 = A|~B, 14 = OR, 15 = 1.
- R3: When control bit 0 is 1, the element output follows its function combinationally, in the same cycle. When bit 0 is 0, the output is the flip-flop. The flip-flop takes the function value at the first clock edge on which its group is enabled.
- R4: When control bit 6 is 0, input A is bit i of the software data word for element i. When bit 6 is 1, input A is the output of feedback selector 0.
- R5: When control bit 5 is 1, input B is pin_in[i]. When bit 5 is 0, input B is the output of feedback selector 1.
- R6: Control bits 10:9 choose element base+2*code for feedback selector 0. Bits 8:7 choose element base+2*code+1 for feedback selector 1. The base is 0 for group 0 and 8 for group 1.
- R7: Clock-select bits 2:0 set the source for group 0 and bits 6:4 set the source for group 1. Code 0 selects ext_tick[0], 1 selects ext_tick[1], 2 selects ext_tick[2], 3 fires every cycle, 4 selects ext_tick[3] and 5 selects ext_tick[4]. A group's flip-flops hold their value on every cycle in which the selected source does not fire.
- R8: Clock-select codes 6 and 7 keep that group's flip-flops frozen, whatever the strobe inputs do.
- R9: Unused bits read as zero and writes to them have no effect: bits 31:11 of a control word, bits 31:7 and bit 3 of the clock-select register, and bits 31:16 of the data word.
- R10: Addresses 0 to 15 hold the control words of elements 0 to 15, address 16 holds the clock-select register and address 17 holds the data word. Every other address reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one register |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Combinational read data |
| pin_in | input | 16 | External input pin of each element |
| ext_tick | input | 5 | Enable strobes of the five external clock sources |
| cell_out | output | 16 | Output of each element |

## Verification
On every cycle, the assertions check that an element's flip-flop holds unless its group is enabled and captures the function value when it is. They also check that the system-clock code always enables its group, that reserved codes never do, that a write lands in the addressed control word, and that unused read bits stay zero. The bench's scenarios are needed for the rest: the sixteen function codes over all input pairs, the input source choices, the feedback routing to the correct even and odd elements in each group, and the independence of the two groups' clock selections.

// File: rtl/lcf_pkg.sv
package lcf_pkg;

  localparam int CFG_W = 11;

  // Control word layout, MSB first: fb0 10:9, fb1 8:7, a-src 6, b-src 5, truth 4:1, bypass 0
  typedef struct packed {
    logic [1:0] fb0_sel;
    logic [1:0] fb1_sel;
    logic       a_from_fb;
    logic       b_from_pin;
    logic [3:0] truth;
    logic       bypass;
  } cell_cfg_t;

  // Truth-table lookup: A weighs 2, B weighs 1
  function automatic logic lut_eval(input logic [3:0] truth, input logic a, input logic b);
    return truth[{a, b}];
  endfunction

  // Clock-source code to enable strobe; code 3 is the system clock, 6 and 7 freeze
  function automatic logic src_enable(input logic [2:0] code, input logic [4:0] ext);
    case (code)
      3'd0:    return ext[0];
      3'd1:    return ext[1];
      3'd2:    return ext[2];
      3'd3:    return 1'b1;
      3'd4:    return ext[3];
      3'd5:    return ext[4];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lcf_regs.sv
module lcf_regs
  import lcf_pkg::*;
#(
  parameter int NUM_CELLS  = 16,
  parameter int NUM_GROUPS = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [DATA_W-1:0]               rd_data,
  output cell_cfg_t [NUM_CELLS-1:0]       cfg_o,
  output logic [NUM_GROUPS-1:0][2:0]      clk_sel_o,
  output logic [NUM_CELLS-1:0]            sw_data_o
);

  localparam int CELL_IDX_W = $clog2(NUM_CELLS);
  localparam logic [ADDR_W-1:0] ADDR_CLK  = ADDR_W'(NUM_CELLS);
  localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(NUM_CELLS + 1);

  cell_cfg_t [NUM_CELLS-1:0]  cfg_q;
  logic [NUM_GROUPS-1:0][2:0] clk_sel_q;
  logic [NUM_CELLS-1:0]       sw_data_q;

  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:NUM_CELLS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      clk_sel_q <= '0;
      sw_data_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_CELLS; i++)
        if (wr_addr == ADDR_W'(i)) cfg_q[i] <= cell_cfg_t'(wr_data[CFG_W-1:0]);
      if (wr_addr == ADDR_CLK)
        for (int g = 0; g < NUM_GROUPS; g++) clk_sel_q[g] <= wr_data[4*g +: 3];
      if (wr_addr == ADDR_DATA) sw_data_q <= wr_data[NUM_CELLS-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_CLK)
      rd_data[CFG_W-1:0] = cfg_q[rd_addr[CELL_IDX_W-1:0]];
    else if (rd_addr == ADDR_CLK)
      for (int g = 0; g < NUM_GROUPS; g++) rd_data[4*g +: 3] = clk_sel_q[g];
    else if (rd_addr == ADDR_DATA)
      rd_data[NUM_CELLS-1:0] = sw_data_q;
  end

  assign cfg_o     = cfg_q;
  assign clk_sel_o = clk_sel_q;
  assign sw_data_o = sw_data_q;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cfg_chk
    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(i)) |=> (cfg_q[i] == $past(wr_data[CFG_W-1:0])))
      else $error("cfg write lost"); // R10
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr < ADDR_CLK) |-> (rd_data[DATA_W-1:CFG_W] == '0))
    else $error("reserved cfg bits nonzero"); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr > ADDR_DATA) |-> (rd_data == '0))
    else $error("unmapped read nonzero"); // R10

endmodule

// File: rtl/lcf_clk_sel.sv
module lcf_clk_sel
  import lcf_pkg::*;
(
  input  logic [2:0] code_i,
  input  logic [4:0] ext_tick_i,
  output logic       tick_o
);

  assign tick_o = src_enable(code_i, ext_tick_i);

endmodule

// File: rtl/lcf_cell.sv
module lcf_cell
  import lcf_pkg::*;
#(
  parameter int FB_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cell_cfg_t       cfg_i,
  input  logic            tick_i,
  input  logic            sw_bit_i,
  input  logic            pin_i,
  input  logic [FB_N-1:0] fb_even_i,
  input  logic [FB_N-1:0] fb_odd_i,
  output logic            out_o
);

  logic in_a, in_b, fn_val, ff_q;

  assign in_a   = cfg_i.a_from_fb  ? fb_even_i[cfg_i.fb0_sel] : sw_bit_i;
  assign in_b   = cfg_i.b_from_pin ? pin_i : fb_odd_i[cfg_i.fb1_sel];
  assign fn_val = lut_eval(cfg_i.truth, in_a, in_b);

  always_ff @(posedge clk) begin
    if (!rst_n)      ff_q <= 1'b0;
    else if (tick_i) ff_q <= fn_val;
  end

  assign out_o = cfg_i.bypass ? fn_val : ff_q;

  AST_FF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(ff_q))
    else $error("flip-flop moved without enable"); // R7

  AST_FF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (ff_q == $past(fn_val)))
    else $error("flip-flop missed capture"); // R3

endmodule

// File: rtl/lcf_fabric.sv
module lcf_fabric
  import lcf_pkg::*;
#(
  parameter int NUM_CELLS  = 16,
  parameter int GROUP_SIZE = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int EXT_SRC    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [NUM_CELLS-1:0] pin_in,
  input  logic [EXT_SRC-1:0]   ext_tick,
  output logic [NUM_CELLS-1:0] cell_out
);

  localparam int NUM_GROUPS = NUM_CELLS / GROUP_SIZE;
  localparam int FB_N       = GROUP_SIZE / 2;

  cell_cfg_t [NUM_CELLS-1:0]  cfg;
  logic [NUM_GROUPS-1:0][2:0] clk_sel;
  logic [NUM_CELLS-1:0]       sw_data;
  logic [NUM_GROUPS-1:0]      grp_tick;

  lcf_regs #(
    .NUM_CELLS(NUM_CELLS), .NUM_GROUPS(NUM_GROUPS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cfg_o(cfg), .clk_sel_o(clk_sel),
    .sw_data_o(sw_data)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    lcf_clk_sel u_cs (.code_i(clk_sel[g]), .ext_tick_i(ext_tick), .tick_o(grp_tick[g]));

    AST_SYSCLK_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel[g] == 3'd3) |-> grp_tick[g])
      else $error("system clock source idle"); // R7

    AST_RSVD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel[g][2:1] == 2'b11) |-> !grp_tick[g])
      else $error("reserved source enabled"); // R8
  end

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    localparam int BASE = (i / GROUP_SIZE) * GROUP_SIZE;
    logic [FB_N-1:0] fb_even, fb_odd;

    for (genvar k = 0; k < FB_N; k++) begin : g_fb
      assign fb_even[k] = cell_out[BASE + 2*k];
      assign fb_odd[k]  = cell_out[BASE + 2*k + 1];
    end

    lcf_cell #(.FB_N(FB_N)) u_cell (
      .clk(clk), .rst_n(rst_n), .cfg_i(cfg[i]), .tick_i(grp_tick[i / GROUP_SIZE]),
      .sw_bit_i(sw_data[i]), .pin_i(pin_in[i]), .fb_even_i(fb_even),
      .fb_odd_i(fb_odd), .out_o(cell_out[i])
    );
  end

endmodule

// File: tb/lcf_fabric_tb.sv
module lcf_fabric_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] pin_in = '0;
  logic [4:0]  ext_tick = '0;
  logic [15:0] cell_out;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcf_fabric dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .ext_tick(ext_tick),
    .cell_out(cell_out)
  );

  // {code[3:0], a, b} mixed patterns
  localparam logic [5:0] VEC [16] = '{
    6'b0000_11, 6'b0001_00, 6'b0010_01, 6'b0011_10, 6'b0100_10, 6'b0101_01,
    6'b0110_11, 6'b0111_11, 6'b1000_11, 6'b1001_01, 6'b1010_10, 6'b1011_10,
    6'b1100_10, 6'b1101_01, 6'b1110_00, 6'b1111_00
  };

  function automatic logic ref_fn(input int code, input logic a, input logic b);
    case (code)
      0:  return 1'b0;
      1:  return ~(a | b);
      2:  return b & ~a;
      3:  return ~a;
      4:  return a & ~b;
      5:  return ~b;
      6:  return a ^ b;
      7:  return ~(a & b);
      8:  return a & b;
      9:  return ~(a ^ b);
      10: return b;
      11: return ~a | b;
      12: return a;
      13: return a | ~b;
      14: return a | b;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    rd_addr = 5'(addr);
    #1 data = rd_data;
  endtask

  task automatic pulse(input logic [4:0] mask);
    @(negedge clk); ext_tick = mask;
    @(negedge clk); ext_tick = '0;
  endtask

  task automatic set_fn(input int code, input logic a, input logic b);
    wr(0, 32'((1 << 5) | (code << 1) | 1));
    wr(17, 32'(a));
    pin_in[0] = b;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", 32'(cell_out), 32'h0);
    rd(0, r);  chk("R1 cfg0", r, 0);
    rd(16, r); chk("R1 clksel", r, 0);
    rd(17, r); chk("R1 data", r, 0);

    // R2 table walk, bypass path (R3), A from data word (R4), B from pin (R5)
    for (int v = 0; v < 16; v++) begin
      set_fn(int'(VEC[v][5:2]), VEC[v][1], VEC[v][0]);
      chk("R2 table", 32'(cell_out[0]), 32'(ref_fn(int'(VEC[v][5:2]), VEC[v][1], VEC[v][0])));
    end
    for (int c = 0; c < 16; c++)
      for (int ab = 0; ab < 4; ab++) begin
        set_fn(c, ab[1], ab[0]);
        chk("R2 sweep", 32'(cell_out[0]), 32'(ref_fn(c, ab[1], ab[0])));
      end
    set_fn(6, 1'b1, 1'b0);
    pin_in[0] = 1'b1; #1;
    chk("R3 comb same cycle", 32'(cell_out[0]), 32'h0);

    // R6 feedback group 0: elem2 = elem4 AND elem3
    wr(4, 32'h19); wr(3, 32'h35); wr(2, 32'h4D1);
    wr(17, 32'h10); pin_in[3] = 1'b1; #1;
    chk("R6 fb g0 11", 32'(cell_out[2]), 32'h1);
    pin_in[3] = 1'b0; #1;
    chk("R6 fb g0 10", 32'(cell_out[2]), 32'h0);
    wr(17, 32'h0); pin_in[3] = 1'b1; #1;
    chk("R6 fb g0 01", 32'(cell_out[2]), 32'h0);
    // R6 feedback group 1: elem9 = elem14 XOR elem11
    wr(14, 32'h19); wr(11, 32'h35); wr(9, 32'h6CD);
    wr(17, 32'h4000); pin_in[11] = 1'b0; #1;
    chk("R6 fb g1 10", 32'(cell_out[9]), 32'h1);
    pin_in[11] = 1'b1; #1;
    chk("R6 fb g1 11", 32'(cell_out[9]), 32'h0);

    // R3 registered path, group 0 on system clock (R7 code 3)
    wr(16, 32'h03); wr(1, 32'h18);
    wr(17, 32'h2);
    chk("R3 reg lag", 32'(cell_out[1]), 32'h0);
    @(negedge clk);
    chk("R3 reg capture", 32'(cell_out[1]), 32'h1);

    // R7 code 0 uses ext_tick[0]
    wr(16, 32'h00); wr(17, 32'h0);
    repeat (3) @(negedge clk);
    chk("R7 hold", 32'(cell_out[1]), 32'h1);
    pulse(5'b00010);
    chk("R7 wrong source", 32'(cell_out[1]), 32'h1);
    pulse(5'b00001);
    chk("R7 src0 capture", 32'(cell_out[1]), 32'h0);
    // R7 code 4 uses ext_tick[3]
    wr(16, 32'h04); wr(17, 32'h2);
    pulse(5'b10111);
    chk("R7 code4 not other", 32'(cell_out[1]), 32'h0);
    pulse(5'b01000);
    chk("R7 code4 capture", 32'(cell_out[1]), 32'h1);

    // R8 reserved codes freeze
    wr(16, 32'h06); wr(17, 32'h0);
    pulse(5'b11111); pulse(5'b11111);
    chk("R8 code6 frozen", 32'(cell_out[1]), 32'h1);
    wr(16, 32'h07);
    pulse(5'b11111);
    chk("R8 code7 frozen", 32'(cell_out[1]), 32'h1);

    // R7 per-group: group1 system clock, group0 code 0 with no strobes
    wr(8, 32'h18); wr(16, 32'h30);
    wr(17, 32'h100);
    @(negedge clk);
    chk("R7 group1 capture", 32'(cell_out[8]), 32'h1);
    chk("R7 group0 held", 32'(cell_out[1]), 32'h1);

    // R9 reserved bits
    wr(5, 32'hFFFF_FFFF);  rd(5, r);  chk("R9 cfg rsvd", r, 32'h7FF);
    wr(16, 32'hFFFF_FFFF); rd(16, r); chk("R9 clksel rsvd", r, 32'h77);
    wr(17, 32'hFFFF_FFFF); rd(17, r); chk("R9 data rsvd", r, 32'hFFFF);

    // R10 unmapped address
    wr(20, 32'h0); rd(20, r); chk("R10 unmapped read", r, 32'h0);
    rd(5, r);  chk("R10 cfg untouched", r, 32'h7FF);
    rd(16, r); chk("R10 clksel untouched", r, 32'h77);
    rd(17, r); chk("R10 data untouched", r, 32'hFFFF);
    rd(2, r);  chk("R10 cfg2 readback", r, 32'h4D1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule